// File: doc/BRIEF.md
# FIFO Level Trigger Generator

This block sits beside the receive and transmit FIFOs of a serial peripheral. It raises a trigger event when a FIFO's occupancy reaches a programmed point. Both FIFOs have the same depth. The FIFO logic gives the block its push and pop strobes and its occupancy count for the current cycle. The block works out the occupancy after that cycle's operation and compares it with the programmed point. It then drives a sticky status flag, an interrupt line and a level-based DMA request for each direction.

Each direction has an enable bit and a trigger code, both set through a simple write port. The receive code is one less than the level that fires. It is checked only when an entry arrives. The transmit code is the level that fires. It is checked only when an entry leaves. Interrupt and DMA enables are inputs, one pair for each direction, so the surrounding logic chooses where each event goes.

Top module: `fifo_lvl_trig`

## Requirements
- R1: With the receive trigger enabled and code N, a push-only cycle whose resulting receive level equals N+1 sets `rx_flag` in the following cycle. Code 0 fires on the first entry and code DEPTH-1 fires when the FIFO becomes full. A push while the FIFO is already full never fires.
- R2: The receive comparison happens only on push-only cycles. A pop-only cycle or an idle cycle never sets `rx_flag`, whatever the level is.
- R3: With the transmit trigger enabled and code M, a pop-only cycle from a non-empty FIFO whose resulting level equals M sets `tx_flag` in the following cycle. Code 0 fires when the FIFO becomes empty and code DEPTH-1 fires when it stops being full.
- R4: A push-only cycle on the transmit FIFO never sets `tx_flag`, even when the resulting level equals M.
- R5: While a direction's enable bit is 0, its trigger code is ignored. That direction produces neither a flag nor a DMA request.
- R6: `rx_flag` and `tx_flag` stay set until their clear strobe (`rx_clr`, `tx_clr`) is high for a cycle. If a trigger event and a clear fall in the same cycle, the flag ends up set.
- R7: `irq` is high whenever `rx_flag` and `rx_int_en` are both high, or `tx_flag` and `tx_int_en` are both high. Otherwise it is low.
- R8: `rx_dma_req` is high in the cycle after any cycle in which the receive trigger is enabled, `rx_dma_en` is high and the resulting receive level is at least N+1. `tx_dma_req` behaves the same way when the resulting transmit level is at most M.
- R9: A cycle with both a push and a pop on the same FIFO leaves the level unchanged and creates no trigger event.
- R10: Reset clears both enable bits, both codes, both flags and both DMA requests.
- R11: A trigger setting written with `cfg_we` is used from the following cycle on. A push or pop in the write cycle is judged with the old setting. A new setting never fires for a level that is already reached without a new push or pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the trigger setting |
| cfg_rx_ena | input | 1 | Receive trigger enable, written on `cfg_we` |
| cfg_rx_pt | input | PW (4) | Receive trigger code, written on `cfg_we` |
| cfg_tx_ena | input | 1 | Transmit trigger enable, written on `cfg_we` |
| cfg_tx_pt | input | PW (4) | Transmit trigger code, written on `cfg_we` |
| rx_push | input | 1 | Receive FIFO write strobe |
| rx_pop | input | 1 | Receive FIFO read strobe |
| rx_level | input | LW (5) | Receive occupancy before this cycle's operation |
| tx_push | input | 1 | Transmit FIFO write strobe |
| tx_pop | input | 1 | Transmit FIFO read strobe |
| tx_level | input | LW (5) | Transmit occupancy before this cycle's operation |
| rx_int_en | input | 1 | Routes the receive flag to `irq` |
| tx_int_en | input | 1 | Routes the transmit flag to `irq` |
| rx_dma_en | input | 1 | Allows the receive DMA request |
| tx_dma_en | input | 1 | Allows the transmit DMA request |
| rx_clr | input | 1 | Clear strobe for `rx_flag` |
| tx_clr | input | 1 | Clear strobe for `tx_flag` |
| rx_flag | output | 1 | Sticky receive trigger status |
| tx_flag | output | 1 | Sticky transmit trigger status |
| irq | output | 1 | Combined interrupt request |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |

## Verification
The bench builds the block at its default depth of 16. This gives a 4-bit code and a 5-bit level, so each code extreme can be reached directly: the first receive entry, the full receive FIFO, a push into a full FIFO, a transmit FIFO that empties, and a transmit FIFO that stops being full. Because the level is an input, the bench can place any occupancy next to any strobe pattern without filling a real FIFO. This lets it check the push-only, pop-only, simultaneous and idle cases at the same level against one fixed setting.

// File: rtl/fifo_lvl_trig_pkg.sv
package fifo_lvl_trig_pkg;

    // Which side of the peripheral a detector serves; picks the compare rule.
    typedef enum logic {
        DIR_RX = 1'b0,
        DIR_TX = 1'b1
    } dir_e;

    localparam int unsigned NUM_DIR = 2;

endpackage

// File: rtl/fifo_lvl_cfg.sv
module fifo_lvl_cfg
    import fifo_lvl_trig_pkg::*;
#(
    parameter int unsigned PW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          rx_ena_wr,
    input  logic [PW-1:0] rx_pt_wr,
    input  logic          tx_ena_wr,
    input  logic [PW-1:0] tx_pt_wr,
    output logic          ena_o [NUM_DIR],
    output logic [PW-1:0] pt_o  [NUM_DIR]
);

    typedef struct packed {
        logic          rx_ena;
        logic [PW-1:0] rx_pt;
        logic          tx_ena;
        logic [PW-1:0] tx_pt;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            cfg_d.rx_ena = rx_ena_wr;
            cfg_d.rx_pt  = rx_pt_wr;
            cfg_d.tx_ena = tx_ena_wr;
            cfg_d.tx_pt  = tx_pt_wr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign ena_o[DIR_RX] = cfg_q.rx_ena;
    assign pt_o[DIR_RX]  = cfg_q.rx_pt;
    assign ena_o[DIR_TX] = cfg_q.tx_ena;
    assign pt_o[DIR_TX]  = cfg_q.tx_pt;

endmodule

// File: rtl/fifo_lvl_dir.sv
module fifo_lvl_dir
    import fifo_lvl_trig_pkg::*;
#(
    parameter dir_e        DIR   = DIR_RX,
    parameter int unsigned DEPTH = 16,
    parameter int unsigned LW    = $clog2(DEPTH + 1),
    parameter int unsigned PW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ena,
    input  logic [PW-1:0] pt,
    input  logic          push,
    input  logic          pop,
    input  logic [LW-1:0] level,
    input  logic          dma_en,
    input  logic          clr,
    output logic          flag,
    output logic          dma_req
);

    localparam int unsigned XW = LW + 1;
    localparam logic [XW-1:0] FULL = XW'(DEPTH);

    typedef struct packed {
        logic flag;
        logic dma;
    } st_t;

    st_t st_d, st_q;

    logic          push_only;
    logic          pop_only;
    logic [XW-1:0] lvl_x;
    logic [XW-1:0] lvl_nxt;
    logic [XW-1:0] pt_x;
    logic          hit;
    logic          meet;

    assign push_only = push & ~pop;
    assign pop_only  = pop & ~push;
    assign lvl_x     = XW'(level);
    assign pt_x      = XW'(pt);

    // Occupancy once this cycle's operation has landed.
    always_comb begin
        lvl_nxt = lvl_x;
        if (push_only && (lvl_x < FULL)) begin
            lvl_nxt = lvl_x + XW'(1);
        end else if (pop_only && (lvl_x != '0)) begin
            lvl_nxt = lvl_x - XW'(1);
        end
    end

    generate
        if (DIR == DIR_RX) begin : g_rx
            logic [XW-1:0] goal;
            assign goal = pt_x + XW'(1);
            assign hit  = ena & push_only & (lvl_x < FULL) & (lvl_nxt == goal);
            assign meet = ena & dma_en & (lvl_nxt >= goal);
        end else begin : g_tx
            assign hit  = ena & pop_only & (lvl_x != '0) & (lvl_nxt == pt_x);
            assign meet = ena & dma_en & (lvl_nxt <= pt_x);
        end
    endgenerate

    always_comb begin
        st_d      = st_q;
        st_d.flag = hit | (st_q.flag & ~clr);
        st_d.dma  = meet;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag    = st_q.flag;
    assign dma_req = st_q.dma;

endmodule

// File: rtl/fifo_lvl_trig.sv
module fifo_lvl_trig
    import fifo_lvl_trig_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned LW    = $clog2(DEPTH + 1),
    parameter int unsigned PW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic          cfg_rx_ena,
    input  logic [PW-1:0] cfg_rx_pt,
    input  logic          cfg_tx_ena,
    input  logic [PW-1:0] cfg_tx_pt,
    input  logic          rx_push,
    input  logic          rx_pop,
    input  logic [LW-1:0] rx_level,
    input  logic          tx_push,
    input  logic          tx_pop,
    input  logic [LW-1:0] tx_level,
    input  logic          rx_int_en,
    input  logic          tx_int_en,
    input  logic          rx_dma_en,
    input  logic          tx_dma_en,
    input  logic          rx_clr,
    input  logic          tx_clr,
    output logic          rx_flag,
    output logic          tx_flag,
    output logic          irq,
    output logic          rx_dma_req,
    output logic          tx_dma_req
);

    logic          ena_w   [NUM_DIR];
    logic [PW-1:0] pt_w    [NUM_DIR];
    logic          push_w  [NUM_DIR];
    logic          pop_w   [NUM_DIR];
    logic [LW-1:0] lvl_w   [NUM_DIR];
    logic          dmae_w  [NUM_DIR];
    logic          clr_w   [NUM_DIR];
    logic          flag_w  [NUM_DIR];
    logic          dreq_w  [NUM_DIR];
    logic          inte_w  [NUM_DIR];
    logic [NUM_DIR-1:0] irq_src;

    assign push_w[DIR_RX] = rx_push;
    assign pop_w[DIR_RX]  = rx_pop;
    assign lvl_w[DIR_RX]  = rx_level;
    assign dmae_w[DIR_RX] = rx_dma_en;
    assign clr_w[DIR_RX]  = rx_clr;
    assign inte_w[DIR_RX] = rx_int_en;
    assign push_w[DIR_TX] = tx_push;
    assign pop_w[DIR_TX]  = tx_pop;
    assign lvl_w[DIR_TX]  = tx_level;
    assign dmae_w[DIR_TX] = tx_dma_en;
    assign clr_w[DIR_TX]  = tx_clr;
    assign inte_w[DIR_TX] = tx_int_en;

    fifo_lvl_cfg #(
        .PW (PW)
    ) cfg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .rx_ena_wr (cfg_rx_ena),
        .rx_pt_wr  (cfg_rx_pt),
        .tx_ena_wr (cfg_tx_ena),
        .tx_pt_wr  (cfg_tx_pt),
        .ena_o     (ena_w),
        .pt_o      (pt_w)
    );

    generate
        for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
            fifo_lvl_dir #(
                .DIR   (dir_e'(d)),
                .DEPTH (DEPTH),
                .LW    (LW),
                .PW    (PW)
            ) dir_i (
                .clk     (clk),
                .rst_n   (rst_n),
                .ena     (ena_w[d]),
                .pt      (pt_w[d]),
                .push    (push_w[d]),
                .pop     (pop_w[d]),
                .level   (lvl_w[d]),
                .dma_en  (dmae_w[d]),
                .clr     (clr_w[d]),
                .flag    (flag_w[d]),
                .dma_req (dreq_w[d])
            );
            assign irq_src[d] = flag_w[d] & inte_w[d];
        end
    endgenerate

    assign rx_flag    = flag_w[DIR_RX];
    assign tx_flag    = flag_w[DIR_TX];
    assign rx_dma_req = dreq_w[DIR_RX];
    assign tx_dma_req = dreq_w[DIR_TX];
    assign irq        = |irq_src;

endmodule

// File: rtl/fifo_lvl_trig_chk.sv
module fifo_lvl_trig_chk (
    input logic clk,
    input logic rst_n,
    input logic rx_push,
    input logic rx_pop,
    input logic tx_push,
    input logic tx_pop,
    input logic rx_dma_en,
    input logic tx_dma_en,
    input logic rx_clr,
    input logic tx_clr,
    input logic rx_flag,
    input logic tx_flag,
    input logic rx_dma_req,
    input logic tx_dma_req
);

    // R2
    rx_rise_needs_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_flag) |-> $past(rx_push && !rx_pop));

    // R4
    tx_rise_needs_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_flag) |-> $past(tx_pop && !tx_push));

    // R6
    rx_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_flag && !rx_clr) |=> rx_flag);

    // R6
    tx_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_flag && !tx_clr) |=> tx_flag);

    // R6
    rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_clr && !rx_push) |=> !rx_flag);

    // R6
    tx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_clr && !tx_pop) |=> !tx_flag);

    // R9
    rx_both_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_pop && !rx_flag) |=> !rx_flag);

    // R9
    tx_both_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_push && tx_pop && !tx_flag) |=> !tx_flag);

    // R8
    rx_dma_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_dma_en |=> !rx_dma_req);

    // R8
    tx_dma_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_dma_en |=> !tx_dma_req);

endmodule

bind fifo_lvl_trig fifo_lvl_trig_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_push    (rx_push),
    .rx_pop     (rx_pop),
    .tx_push    (tx_push),
    .tx_pop     (tx_pop),
    .rx_dma_en  (rx_dma_en),
    .tx_dma_en  (tx_dma_en),
    .rx_clr     (rx_clr),
    .tx_clr     (tx_clr),
    .rx_flag    (rx_flag),
    .tx_flag    (tx_flag),
    .rx_dma_req (rx_dma_req),
    .tx_dma_req (tx_dma_req)
);

// File: tb/fifo_lvl_trig_tb_top.sv
module fifo_lvl_trig_tb_top;

    localparam int unsigned DEPTH = 16;
    localparam int unsigned LW    = $clog2(DEPTH + 1);
    localparam int unsigned PW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic          cfg_rx_ena = 1'b0;
    logic [PW-1:0] cfg_rx_pt = '0;
    logic          cfg_tx_ena = 1'b0;
    logic [PW-1:0] cfg_tx_pt = '0;
    logic          rx_push = 1'b0;
    logic          rx_pop = 1'b0;
    logic [LW-1:0] rx_level = '0;
    logic          tx_push = 1'b0;
    logic          tx_pop = 1'b0;
    logic [LW-1:0] tx_level = '0;
    logic          rx_int_en = 1'b0;
    logic          tx_int_en = 1'b0;
    logic          rx_dma_en = 1'b0;
    logic          tx_dma_en = 1'b0;
    logic          rx_clr = 1'b0;
    logic          tx_clr = 1'b0;
    logic          rx_flag, tx_flag, irq, rx_dma_req, tx_dma_req;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    fifo_lvl_trig #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_rx_ena(cfg_rx_ena), .cfg_rx_pt(cfg_rx_pt),
        .cfg_tx_ena(cfg_tx_ena), .cfg_tx_pt(cfg_tx_pt),
        .rx_push(rx_push), .rx_pop(rx_pop), .rx_level(rx_level),
        .tx_push(tx_push), .tx_pop(tx_pop), .tx_level(tx_level),
        .rx_int_en(rx_int_en), .tx_int_en(tx_int_en),
        .rx_dma_en(rx_dma_en), .tx_dma_en(tx_dma_en),
        .rx_clr(rx_clr), .tx_clr(tx_clr),
        .rx_flag(rx_flag), .tx_flag(tx_flag), .irq(irq),
        .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req)
    );

    // Layout: [15] rx push, [14] rx pop, [13:9] rx level, [8] tx push,
    // [7] tx pop, [6:2] tx level, [1] expected rx flag, [0] expected tx flag.
    // Setting in force: rx enabled code 3, tx enabled code 2.
    localparam int NVEC = 11;
    localparam logic [15:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 5'd3, 1'b0, 1'b0, 5'd0, 2'b10}, // R1 push 3->4
        {1'b1, 1'b0, 5'd2, 1'b0, 1'b0, 5'd0, 2'b00}, // R1 push 2->3
        {1'b1, 1'b0, 5'd4, 1'b0, 1'b0, 5'd0, 2'b00}, // R1 push 4->5
        {1'b0, 1'b1, 5'd5, 1'b0, 1'b0, 5'd0, 2'b00}, // R2 pop 5->4
        {1'b1, 1'b1, 5'd3, 1'b0, 1'b0, 5'd0, 2'b00}, // R9 rx both
        {1'b0, 1'b0, 5'd0, 1'b0, 1'b1, 5'd3, 2'b01}, // R3 pop 3->2
        {1'b0, 1'b0, 5'd0, 1'b0, 1'b1, 5'd4, 2'b00}, // R3 pop 4->3
        {1'b0, 1'b0, 5'd0, 1'b1, 1'b0, 5'd1, 2'b00}, // R4 push 1->2
        {1'b0, 1'b0, 5'd0, 1'b1, 1'b1, 5'd2, 2'b00}, // R9 tx both
        {1'b1, 1'b0, 5'd3, 1'b0, 1'b1, 5'd3, 2'b11}, // R1 R3 together
        {1'b0, 1'b0, 5'd4, 1'b0, 1'b0, 5'd2, 2'b00}  // R2 idle at level
    };

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic quiet();
        rx_push = 0; rx_pop = 0; tx_push = 0; tx_pop = 0;
        rx_clr = 0; tx_clr = 0; cfg_we = 0;
    endtask

    task automatic wcfg(input logic re, input logic [PW-1:0] rp, input logic te, input logic [PW-1:0] tp);
        quiet();
        cfg_we = 1; cfg_rx_ena = re; cfg_rx_pt = rp; cfg_tx_ena = te; cfg_tx_pt = tp;
        tick();
        cfg_we = 0;
    endtask

    task automatic clear_all();
        quiet();
        rx_clr = 1; tx_clr = 1;
        tick();
        quiet();
    endtask

    task automatic rx_op(input logic pu, input logic po, input int lvl);
        quiet();
        rx_push = pu; rx_pop = po; rx_level = LW'(lvl);
        tick();
        quiet();
    endtask

    task automatic tx_op(input logic pu, input logic po, input int lvl);
        quiet();
        tx_push = pu; tx_pop = po; tx_level = LW'(lvl);
        tick();
        quiet();
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    initial begin
        // R10 reset state
        rx_int_en = 1; tx_int_en = 1; rx_dma_en = 1; tx_dma_en = 1;
        repeat (3) tick();
        chk("R10", "rx_flag in reset", rx_flag, 1'b0);
        chk("R10", "tx_flag in reset", tx_flag, 1'b0);
        chk("R10", "irq in reset", irq, 1'b0);
        rst_n = 1;
        tick();
        // R10 setting cleared: level 0 matches code 0 of both sides
        rx_op(1, 0, 0);
        tx_op(0, 1, 1);
        chk("R10", "rx_flag after reset setting", rx_flag, 1'b0);
        chk("R10", "tx_flag after reset setting", tx_flag, 1'b0);
        chk("R10", "rx_dma_req after reset setting", rx_dma_req, 1'b0);
        chk("R10", "tx_dma_req after reset setting", tx_dma_req, 1'b0);
        rx_int_en = 0; tx_int_en = 0; rx_dma_en = 0; tx_dma_en = 0;

        // Vector table
        wcfg(1, 4'd3, 1, 4'd2);
        for (int i = 0; i < NVEC; i++) begin
            clear_all();
            rx_push = VEC[i][15]; rx_pop = VEC[i][14]; rx_level = VEC[i][13:9];
            tx_push = VEC[i][8];  tx_pop = VEC[i][7];  tx_level = VEC[i][6:2];
            tick();
            quiet();
            chk("R1/R2/R9 vec", "rx_flag", rx_flag, VEC[i][1]);
            chk("R3/R4/R9 vec", "tx_flag", tx_flag, VEC[i][0]);
        end

        // R1 code extremes
        wcfg(1, 4'd0, 0, 4'd0); clear_all();
        rx_op(1, 0, 0);
        chk("R1", "code 0 first entry", rx_flag, 1'b1);
        wcfg(1, 4'd15, 0, 4'd0); clear_all();
        rx_op(1, 0, 15);
        chk("R1", "code 15 becomes full", rx_flag, 1'b1);
        clear_all();
        rx_op(1, 0, 16);
        chk("R1", "push into full FIFO", rx_flag, 1'b0);

        // R3 code extremes
        wcfg(0, 4'd0, 1, 4'd0); clear_all();
        tx_op(0, 1, 1);
        chk("R3", "code 0 becomes empty", tx_flag, 1'b1);
        clear_all();
        tx_op(0, 1, 0);
        chk("R3", "pop of empty FIFO", tx_flag, 1'b0);
        wcfg(0, 4'd0, 1, 4'd15); clear_all();
        tx_op(0, 1, 16);
        chk("R3", "code 15 no longer full", tx_flag, 1'b1);
        clear_all();
        tx_op(0, 1, 15);
        chk("R3", "code 15 pop from 15", tx_flag, 1'b0);

        // R5 disabled sides ignore the code
        rx_dma_en = 1; tx_dma_en = 1;
        wcfg(0, 4'd3, 0, 4'd2); clear_all();
        rx_op(1, 0, 3);
        chk("R5", "rx disabled flag", rx_flag, 1'b0);
        chk("R5", "rx disabled dma", rx_dma_req, 1'b0);
        tx_op(0, 1, 3);
        chk("R5", "tx disabled flag", tx_flag, 1'b0);
        chk("R5", "tx disabled dma", tx_dma_req, 1'b0);
        rx_dma_en = 0; tx_dma_en = 0;

        // R6 sticky and clear
        wcfg(1, 4'd3, 1, 4'd2); clear_all();
        rx_op(1, 0, 3);
        tx_op(0, 1, 3);
        rx_level = 9; tx_level = 9;
        repeat (3) tick();
        chk("R6", "rx_flag held", rx_flag, 1'b1);
        chk("R6", "tx_flag held", tx_flag, 1'b1);
        clear_all();
        chk("R6", "rx_flag cleared", rx_flag, 1'b0);
        chk("R6", "tx_flag cleared", tx_flag, 1'b0);
        quiet();
        rx_clr = 1; rx_push = 1; rx_level = 3;
        tx_clr = 1; tx_pop = 1; tx_level = 3;
        tick();
        quiet();
        chk("R6", "rx event beats clear", rx_flag, 1'b1);
        chk("R6", "tx event beats clear", tx_flag, 1'b1);

        // R7 interrupt routing (both flags set here)
        tx_clr = 1; tick(); quiet();
        chk("R7", "rx flag, int off", irq, 1'b0);
        rx_int_en = 1; #1;
        chk("R7", "rx flag, int on", irq, 1'b1);
        rx_int_en = 0; tx_int_en = 1; #1;
        chk("R7", "tx flag clear, tx int on", irq, 1'b0);
        tx_op(0, 1, 3);
        chk("R7", "tx flag, tx int on", irq, 1'b1);
        tx_int_en = 0; #1;
        chk("R7", "both ints off", irq, 1'b0);

        // R8 DMA requests are level based
        clear_all();
        rx_dma_en = 1; tx_dma_en = 1;
        rx_op(1, 0, 3);
        chk("R8", "rx dma at 4", rx_dma_req, 1'b1);
        rx_level = 6; tick();
        chk("R8", "rx dma held at 6", rx_dma_req, 1'b1);
        rx_op(0, 1, 4);
        chk("R8", "rx dma drops at 3", rx_dma_req, 1'b0);
        tx_level = 2; tick();
        chk("R8", "tx dma at 2", tx_dma_req, 1'b1);
        tx_level = 3; tick();
        chk("R8", "tx dma off at 3", tx_dma_req, 1'b0);
        rx_level = 8; rx_dma_en = 0; tick();
        chk("R8", "rx dma gated by enable", rx_dma_req, 1'b0);
        rx_dma_en = 0; tx_dma_en = 0;

        // R11 no retroactive firing, write cycle uses old setting
        wcfg(0, 4'd0, 0, 4'd0); clear_all();
        rx_level = 4; tx_level = 2;
        wcfg(1, 4'd3, 1, 4'd2);
        rx_level = 4; tx_level = 2;
        repeat (2) tick();
        chk("R11", "rx no retro fire", rx_flag, 1'b0);
        chk("R11", "tx no retro fire", tx_flag, 1'b0);
        wcfg(0, 4'd0, 0, 4'd0);
        quiet();
        cfg_we = 1; cfg_rx_ena = 1; cfg_rx_pt = 4'd3;
        rx_push = 1; rx_level = 3;
        tick();
        quiet();
        chk("R11", "write cycle uses old setting", rx_flag, 1'b0);
        rx_op(1, 0, 3);
        chk("R11", "new setting used next cycle", rx_flag, 1'b1);

        summary();
    end

endmodule